// File: doc/BRIEF.md
# Sequential Array Maximum-Index Finder

This block searches a small external register file for its largest entry and reports that entry's position. It reads one entry per cycle through a scan port and reads the current best candidate through a second port. A single-cycle start pulse begins the search. At the end the block holds the winning index in a register and raises a finish flag for exactly one cycle.

The search seeds the best index with entry 0 and then scans from entry 1 up to the last entry. A scanned entry replaces the best only when it is strictly greater, so on a tie the lower index wins. Values are unsigned. While a search runs, further start pulses have no effect. Between searches the result stays stable, so a consumer may read it at any time after finish.

The register file is not part of the block. Its read data returns in the same cycle as the address.

Top module: `argmax_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, finish is 0, rd_en is 0 and best_idx is 0.
- R2: A start pulse of one cycle that is sampled at a clock edge while the block is idle begins a search. finish is 1 during the fourth cycle after that edge (DEPTH cycles after it) and is 0 in every other cycle of the search.
- R3: rd_en is 1 in exactly the three cycles that follow the starting edge. During those cycles cur_addr is 1, then 2, then 3.
- R4: When finish is 1, best_idx holds the index of the largest entry. best_addr always equals best_idx.
- R5: Replacement needs strictly greater data. When entries are equal, the lowest index among them is reported.
- R6: A start pulse during a search (while rd_en or finish is 1) is ignored. The result is unchanged, finish comes at its normal cycle, and rd_en is 0 in the cycle after finish.
- R7: While idle and start is low, best_idx does not change, even if the register file contents change.
- R8: Data is compared as unsigned. For example, 8'hFF is greater than 8'h7F.
- R9: finish is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search |
| cur_data | input | DATA_W | Register file data at cur_addr |
| best_data | input | DATA_W | Register file data at best_addr |
| rd_en | output | 1 | Scan read enable, high during compare cycles |
| cur_addr | output | IDX_W | Scan read address (loop index) |
| best_addr | output | IDX_W | Second read address (current best index) |
| best_idx | output | IDX_W | Registered index of the maximum |
| finish | output | 1 | One-cycle completion flag |

## Verification
If the loop index is corrupted, it shows on cur_addr in the same compare cycle. It also moves finish away from its fixed cycle, which is seen within four cycles of start. If the best-index register holds a wrong value, it shows on best_addr right away. A bad compare decision shows on best_idx at the next finish. The tests use ties, top-bit values and a winner placed at each position, so that a wrong comparison direction or a non-strict compare changes the reported index. If the controller fails to return to idle or accepts a restart, rd_en rises in the cycle after finish.

// File: rtl/argmax_pkg.sv
// Package: shared types for the sequential maximum-index finder.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package argmax_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;
endpackage

// File: rtl/argmax_ctrl.sv
// Module: argmax_ctrl
// Controller of the search. It waits for start, runs one compare cycle per
// scanned entry and gives one finish cycle.
// Assumes: last_hit is high when the loop index is on the final entry.
module argmax_ctrl
    import argmax_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_hit,
    output logic idx_init,
    output logic idx_step,
    output logic best_init,
    output logic rd_en,
    output logic finish
);
    scan_state_t state_q;
    scan_state_t state_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state and control decode.
    always_comb begin
        state_d   = state_q;
        idx_init  = 1'b0;
        idx_step  = 1'b0;
        best_init = 1'b0;
        rd_en     = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    idx_init  = 1'b1;
                    best_init = 1'b1;
                    state_d   = ST_SCAN;
                end
            end
            ST_SCAN: begin
                rd_en = 1'b1;
                if (last_hit) state_d  = ST_DONE;
                else          idx_step = 1'b1;
            end
            ST_DONE: begin
                finish  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/argmax_idx_reg.sv
// Module: argmax_idx_reg
// Loop index register. init loads 1, step adds 1, otherwise the value holds.
// Assumes: init and step are never high together.
module argmax_idx_reg #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    // Loop index update.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (init) idx <= IDX_W'(1);
        else if (step) idx <= idx + IDX_W'(1);
    end
endmodule

// File: rtl/argmax_best_reg.sv
// Module: argmax_best_reg
// Best-index register. init clears it to 0, load takes the scanned index.
// Assumes: init and load are never high together.
module argmax_best_reg #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             load,
    input  logic [IDX_W-1:0] cand,
    output logic [IDX_W-1:0] best
);
    // Best index update.
    always_ff @(posedge clk) begin
        if (!rst_n)    best <= '0;
        else if (init) best <= '0;
        else if (load) best <= cand;
    end
endmodule

// File: rtl/argmax_cmp.sv
// Module: argmax_cmp
// Unsigned magnitude comparator. gt is high when a is strictly above b.
// Assumes: both operands are unsigned.
module argmax_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt
);
    // Strict unsigned compare.
    always_comb gt = (a > b);
endmodule

// File: rtl/argmax_seq.sv
// Module: argmax_seq (top)
// Finds the index of the largest entry of an external DEPTH-entry register
// file. It reads one entry per cycle and reports the result with a one-cycle
// finish flag.
// Assumes: the register file returns data in the same cycle as the address,
// and DEPTH is at least 2.
module argmax_seq #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] cur_data,
    input  logic [DATA_W-1:0] best_data,
    output logic              rd_en,
    output logic [IDX_W-1:0]  cur_addr,
    output logic [IDX_W-1:0]  best_addr,
    output logic [IDX_W-1:0]  best_idx,
    output logic              finish
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic             idx_init;
    logic             idx_step;
    logic             best_init;
    logic             last_hit;
    logic             cur_gt;
    logic             best_load;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] best_q;

    // Datapath status and load decode.
    always_comb begin
        last_hit  = (idx_q == LAST);
        best_load = rd_en & cur_gt;
    end

    argmax_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_hit  (last_hit),
        .idx_init  (idx_init),
        .idx_step  (idx_step),
        .best_init (best_init),
        .rd_en     (rd_en),
        .finish    (finish)
    );

    argmax_idx_reg #(.IDX_W(IDX_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (idx_init),
        .step  (idx_step),
        .idx   (idx_q)
    );

    argmax_best_reg #(.IDX_W(IDX_W)) u_best (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (best_init),
        .load  (best_load),
        .cand  (idx_q),
        .best  (best_q)
    );

    argmax_cmp #(.W(DATA_W)) u_cmp (
        .a  (cur_data),
        .b  (best_data),
        .gt (cur_gt)
    );

    // Output mapping.
    always_comb begin
        cur_addr  = idx_q;
        best_addr = best_q;
        best_idx  = best_q;
    end
endmodule

// File: rtl/argmax_seq_chk.sv
// Module: argmax_seq_chk
// Checker for argmax_seq. It relates the port behaviour over time and is
// bound to the top module below.
// Assumes: the same parameters as the bound instance.
module argmax_seq_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] cur_data,
    input logic [DATA_W-1:0] best_data,
    input logic              rd_en,
    input logic [IDX_W-1:0]  cur_addr,
    input logic [IDX_W-1:0]  best_addr,
    input logic [IDX_W-1:0]  best_idx,
    input logic              finish
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // R9: finish lasts one cycle.
    a_r9_finish_single: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish);

    // R3: the scan address steps by one while reading.
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cur_addr != LAST) |=> (rd_en && cur_addr == IDX_W'($past(cur_addr) + 1'b1)));

    // R2: finish follows the last compare cycle.
    a_r2_finish_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cur_addr == LAST) |=> (finish && !rd_en));

    // R5: a strictly greater entry becomes the best.
    a_r5_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cur_data > best_data) |=> (best_idx == $past(cur_addr)));

    // R5: an entry that is not greater leaves the best unchanged.
    a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cur_data <= best_data) |=> $stable(best_idx));

    // R6: no read and no restart in the cycle after finish.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !rd_en);

    // R7: the result holds while idle.
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !start) |=> $stable(best_idx));

    // R4: the second read port follows the result.
    a_r4_best_port: assert property (@(posedge clk) disable iff (!rst_n)
        best_addr == best_idx);
endmodule

bind argmax_seq argmax_seq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cur_data  (cur_data),
    .best_data (best_data),
    .rd_en     (rd_en),
    .cur_addr  (cur_addr),
    .best_addr (best_addr),
    .best_idx  (best_idx),
    .finish    (finish)
);

// File: tb/argmax_seq_bench.sv
// Bench for argmax_seq. The driver pushes the expected index into a queue,
// and the monitor pops and compares it when finish is seen.
module argmax_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cur_data;
    logic [7:0] best_data;
    logic       rd_en;
    logic [1:0] cur_addr;
    logic [1:0] best_addr;
    logic [1:0] best_idx;
    logic       finish;

    logic [7:0] mem [4];
    logic [1:0] exp_q [$];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // The register file model, read in the same cycle.
    assign cur_data  = rd_en ? mem[cur_addr] : 8'h00;
    assign best_data = mem[best_addr];

    argmax_seq u_argmax_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cur_data  (cur_data),
        .best_data (best_data),
        .rd_en     (rd_en),
        .cur_addr  (cur_addr),
        .best_addr (best_addr),
        .best_idx  (best_idx),
        .finish    (finish)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_max(input logic [7:0] v [4]);
        logic [1:0] b = 2'd0;
        for (int k = 1; k < 4; k++) if (v[k] > v[b]) b = 2'(k);
        return b;
    endfunction

    // Monitor: pops the expected index when finish is seen (R4).
    always @(negedge clk) begin
        if (rst_n && finish) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected finish", 1, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check(best_idx == e, "R4 result index", best_idx, e);
            end
        end
    end

    // Driver: loads the array, pulses start and checks the timing (R2, R3, R6).
    task automatic run_search(input logic [7:0] v0, input logic [7:0] v1,
                              input logic [7:0] v2, input logic [7:0] v3,
                              input bit inject);
        logic [7:0] v [4];
        v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
        @(negedge clk);
        for (int k = 0; k < 4; k++) mem[k] = v[k];
        exp_q.push_back(ref_max(v));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k < 4; k++) begin
            if (k > 1) @(negedge clk);
            check(rd_en == 1'b1, "R3 rd_en in scan", rd_en, 1);
            check(cur_addr == 2'(k), "R3 scan address", cur_addr, k);
            check(finish == 1'b0, "R2 no early finish", finish, 0);
            start = (inject && k == 2);
        end
        @(negedge clk);
        start = 1'b0;
        check(finish == 1'b1, "R2 finish cycle", finish, 1);
        check(rd_en == 1'b0, "R3 rd_en low at finish", rd_en, 0);
        if (inject) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(finish == 1'b0, "R9 finish single", finish, 0);
        check(rd_en == 1'b0, "R6 no restart", rd_en, 0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) mem[k] = 8'h00;
        repeat (2) @(negedge clk);
        check(finish == 1'b0, "R1 finish in reset", finish, 0);
        check(rd_en == 1'b0, "R1 rd_en in reset", rd_en, 0);
        check(best_idx == 2'd0, "R1 best in reset", best_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(finish == 1'b0 && rd_en == 1'b0, "R1 after release", {finish, rd_en}, 0);
        check(best_idx == 2'd0, "R1 best after release", best_idx, 0);

        run_search(8'd10, 8'd20, 8'd30, 8'd40, 1'b0);   // max at 3
        run_search(8'd90, 8'd20, 8'd30, 8'd40, 1'b0);   // max at 0
        run_search(8'd5, 8'd50, 8'd7, 8'd9, 1'b0);      // max at 1
        run_search(8'd5, 8'd6, 8'd70, 8'd9, 1'b0);      // max at 2
        run_search(8'd33, 8'd33, 8'd33, 8'd33, 1'b0);   // R5 all equal -> 0
        run_search(8'd1, 8'd80, 8'd2, 8'd80, 1'b0);     // R5 tie -> 1
        run_search(8'h7F, 8'h10, 8'hFF, 8'h80, 1'b0);   // R8 unsigned -> 2
        run_search(8'hFF, 8'h00, 8'h00, 8'h7F, 1'b0);   // R8 -> 0
        run_search(8'd3, 8'd9, 8'd4, 8'd1, 1'b1);       // R6 start mid-search
        for (int p = 0; p < 8; p++)
            run_search(8'(p * 37 + 11), 8'(p * 91 + 5), 8'(p * 53 + 200), 8'(p * 17 + 64), 1'b0);

        // R7: result holds while idle even when the array changes.
        run_search(8'd1, 8'd2, 8'd99, 8'd3, 1'b0);
        @(negedge clk);
        mem[0] = 8'hFF;
        mem[3] = 8'hFE;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(best_idx == 2'd2, "R7 idle stable", best_idx, 2);
            check(rd_en == 1'b0 && finish == 1'b0, "R7 idle quiet", {rd_en, finish}, 0);
        end
        check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule